// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This unit sits between instruction fetch and the two issue lanes of a small in-order pipeline that fetches one 64-bit packet per cycle. Each packet holds two 32-bit instructions. The low half (slot 0) carries an ALU or branch operation. The high half (slot 1) carries a load or a store. The unit decodes both halves and checks that each one is of the right kind. It looks for a register dependence from slot 0 onto the address or store data of slot 1. It also looks for a dependence on a load issued in the cycle before. From these checks it enables each issue lane, and it tells fetch whether the packet was taken.

Packets arrive on a valid/ready stream. `pkt_ready` is high in a cycle only when every instruction of the packet has been issued, or deliberately dropped, in that cycle. While `pkt_valid` is high and `pkt_ready` is low, the source must hold `pkt_word` unchanged and keep `pkt_valid` high. `fetch_stall` mirrors that hold condition so that fetch can freeze its program counter. The issue enables have no back-pressure. All outputs are combinational in the current packet and in two pieces of state: a replay flag, set while a packet is being split, and the destination of a load issued in the previous cycle.

Top module: `dual_issue_hazard`

## Requirements
- R1: Slot 0 is `pkt_word[31:0]` and slot 1 is `pkt_word[63:32]`. Inside a slot, the opcode is bits 31:26, rs is 25:21, rt is 20:16 and rd is 15:11.
- R2: Slot 0 accepts four kinds of word:
  - opcode 0x00: register ALU. Writes rd and reads rs and rt.
  - opcodes 0x08 to 0x0F: immediate ALU. Writes rt and reads rs.
  - opcodes 0x04 and 0x05: branch. Reads rs and rt.
  - the nop word.
- R2 (continued): Slot 1 accepts three kinds of word:
  - opcode 0x23: load. Writes rt and reads rs as its base.
  - opcode 0x2B: store. Reads rs as its base and rt as its data.
  - the nop word.
- R2 (continued): Any other word in a slot raises that slot's illegal flag. That slot is not issued and its registers are ignored. The packet is still consumed.
- R3: The all-zero word is a nop. It is never issued and never takes part in a dependence.
- R4: If slot 0 writes a register that slot 1 reads, the packet is split. In the first cycle only slot 0 issues, `pkt_ready` is 0 and `fetch_stall` is 1. In the next cycle, with the same packet held, only slot 1 issues and `pkt_ready` is 1.
- R5: After a cycle in which a load issued, suppose the presented packet has any instruction that is not yet issued and that reads the load's destination. Then nothing issues for exactly one cycle and `fetch_stall` is 1. In the following cycle the packet proceeds.
- R6: Register 0 never creates a dependence, whether it is a source or a destination.
- R7: All outputs follow the inputs in the same cycle. With `pkt_valid` low, every enable, flag and `pkt_ready` is 0, and any pending load shadow expires.
- R8: Reset clears the replay flag and the pending load.
- R9: `pkt_ready` is 1 only when the packet is completely handled, and `fetch_stall` equals `pkt_valid` and not `pkt_ready`.
- R10: A load in slot 1 that writes a register read by slot 0 of the same packet is not a hazard. Both slots issue together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet on `pkt_word` is valid |
| pkt_ready | output | 1 | Packet fully handled this cycle |
| pkt_word | input | 64 | Aligned packet, slot 0 in the low half |
| issue0_en | output | 1 | Issue slot 0 this cycle |
| issue1_en | output | 1 | Issue slot 1 this cycle |
| fetch_stall | output | 1 | Hold fetch, the packet is not consumed |
| illegal0 | output | 1 | Slot 0 holds a word of the wrong kind |
| illegal1 | output | 1 | Slot 1 holds a word of the wrong kind |

## Verification
Every enable, flag, `pkt_ready` and `fetch_stall` depends on the current packet with no register in between, so it is due in the same cycle the packet is presented. The effects that pass through state show up exactly one cycle later: the slot 1 replay of a split packet, and the one-cycle load-use stall. The bench drives the inputs at the falling edge and samples two time units later, well before the next rising edge. A bench-side model advances its own replay and load-shadow state at each rising edge. Every check therefore compares against the cycle in which the result is due.

// File: rtl/dih_pkg.sv
package dih_pkg;

  localparam int INSN_W = 32;
  localparam int RA_W   = 5;
  localparam int OP_W   = 6;
  localparam int NSLOT  = 2;
  localparam int PKT_W  = INSN_W * NSLOT;

  // field positions inside one instruction word
  localparam int OP_LSB = INSN_W - OP_W;
  localparam int RS_LSB = OP_LSB - RA_W;
  localparam int RT_LSB = RS_LSB - RA_W;
  localparam int RD_LSB = RT_LSB - RA_W;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_BR_EQ = 6'h04;
  localparam logic [OP_W-1:0] OPC_BR_NE = 6'h05;
  localparam logic [2:0]      OPC_IMM_HI = 3'b001;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic {
    LANE_ALU = 1'b0,
    LANE_MEM = 1'b1
  } lane_kind_e;

  typedef struct packed {
    logic            legal;
    logic            nop;
    logic            is_load;
    logic            wr_en;
    logic [RA_W-1:0] wr;
    logic            ra_en;
    logic [RA_W-1:0] ra;
    logic            rb_en;
    logic [RA_W-1:0] rb;
  } slot_info_t;

endpackage

// File: rtl/dih_slot_decode.sv
module dih_slot_decode
  import dih_pkg::*;
#(
  parameter lane_kind_e KIND = LANE_ALU
) (
  input  logic [INSN_W-1:0] insn,
  output slot_info_t        info
);

  logic [OP_W-1:0] opc;
  logic [RA_W-1:0] f_rs;
  logic [RA_W-1:0] f_rt;
  logic [RA_W-1:0] f_rd;
  logic            is_zero;

  assign opc     = insn[OP_LSB +: OP_W];
  assign f_rs    = insn[RS_LSB +: RA_W];
  assign f_rt    = insn[RT_LSB +: RA_W];
  assign f_rd    = insn[RD_LSB +: RA_W];
  assign is_zero = (insn == '0);

  if (KIND == LANE_ALU) begin : g_alu
    always_comb begin
      info = '0;
      if (is_zero) begin
        info.legal = 1'b1;
        info.nop   = 1'b1;
      end else if (opc == OPC_REG) begin
        info.legal = 1'b1;
        info.wr_en = 1'b1;
        info.wr    = f_rd;
        info.ra_en = 1'b1;
        info.ra    = f_rs;
        info.rb_en = 1'b1;
        info.rb    = f_rt;
      end else if (opc == OPC_BR_EQ || opc == OPC_BR_NE) begin
        info.legal = 1'b1;
        info.ra_en = 1'b1;
        info.ra    = f_rs;
        info.rb_en = 1'b1;
        info.rb    = f_rt;
      end else if (opc[OP_W-1:OP_W-3] == OPC_IMM_HI) begin
        info.legal = 1'b1;
        info.wr_en = 1'b1;
        info.wr    = f_rt;
        info.ra_en = 1'b1;
        info.ra    = f_rs;
      end
    end
  end else begin : g_mem
    always_comb begin
      info = '0;
      if (is_zero) begin
        info.legal = 1'b1;
        info.nop   = 1'b1;
      end else if (opc == OPC_LOAD) begin
        info.legal   = 1'b1;
        info.is_load = 1'b1;
        info.wr_en   = 1'b1;
        info.wr      = f_rt;
        info.ra_en   = 1'b1;
        info.ra      = f_rs;
      end else if (opc == OPC_STORE) begin
        info.legal = 1'b1;
        info.ra_en = 1'b1;
        info.ra    = f_rs;
        info.rb_en = 1'b1;
        info.rb    = f_rt;
      end
    end
  end

endmodule

// File: rtl/dih_hazard_core.sv
module dih_hazard_core
  import dih_pkg::*;
(
  input  logic            pkt_valid,
  input  slot_info_t      s0,
  input  slot_info_t      s1,
  input  logic            replay_q,
  input  logic            shadow_vld,
  input  logic [RA_W-1:0] shadow_reg,
  output logic            go0,
  output logic            go1,
  output logic            take,
  output logic            hold,
  output logic            split_set,
  output logic            shadow_nxt_vld,
  output logic [RA_W-1:0] shadow_nxt_reg
);

  function automatic logic reads_reg(input logic en,
                                     input logic [RA_W-1:0] src,
                                     input logic [RA_W-1:0] dst);
    return en && (src == dst) && (dst != '0);
  endfunction

  logic use0, use1, load_use, intra_raw, proceed;

  always_comb begin
    use0 = !replay_q &&
           (reads_reg(s0.ra_en, s0.ra, shadow_reg) ||
            reads_reg(s0.rb_en, s0.rb, shadow_reg));
    use1 = reads_reg(s1.ra_en, s1.ra, shadow_reg) ||
           reads_reg(s1.rb_en, s1.rb, shadow_reg);
    load_use = pkt_valid && shadow_vld && (use0 || use1);

    intra_raw = !replay_q && s0.wr_en &&
                (reads_reg(s1.ra_en, s1.ra, s0.wr) ||
                 reads_reg(s1.rb_en, s1.rb, s0.wr));

    proceed   = pkt_valid && !load_use;
    go0       = proceed && !replay_q && s0.legal && !s0.nop;
    go1       = proceed && !intra_raw && s1.legal && !s1.nop;
    take      = proceed && !intra_raw;
    split_set = proceed && intra_raw;
    hold      = pkt_valid && !take;

    shadow_nxt_vld = (go1 && s1.is_load && s1.wr_en) ||
                     (go0 && s0.is_load && s0.wr_en);
    shadow_nxt_reg = s1.is_load ? s1.wr : s0.wr;
  end

endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
  import dih_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [PKT_W-1:0] pkt_word,
  output logic             issue0_en,
  output logic             issue1_en,
  output logic             fetch_stall,
  output logic             illegal0,
  output logic             illegal1
);

  slot_info_t sinfo [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    dih_slot_decode #(
      .KIND((g == 0) ? LANE_ALU : LANE_MEM)
    ) u_dec (
      .insn (pkt_word[g*INSN_W +: INSN_W]),
      .info (sinfo[g])
    );
  end

  logic            replay_q;
  logic            shadow_vld;
  logic [RA_W-1:0] shadow_reg;
  logic            split_set;
  logic            shadow_nxt_vld;
  logic [RA_W-1:0] shadow_nxt_reg;

  dih_hazard_core u_core (
    .pkt_valid      (pkt_valid),
    .s0             (sinfo[0]),
    .s1             (sinfo[1]),
    .replay_q       (replay_q),
    .shadow_vld     (shadow_vld),
    .shadow_reg     (shadow_reg),
    .go0            (issue0_en),
    .go1            (issue1_en),
    .take           (pkt_ready),
    .hold           (fetch_stall),
    .split_set      (split_set),
    .shadow_nxt_vld (shadow_nxt_vld),
    .shadow_nxt_reg (shadow_nxt_reg)
  );

  assign illegal0 = pkt_valid && !sinfo[0].legal;
  assign illegal1 = pkt_valid && !sinfo[1].legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_q   <= 1'b0;
      shadow_vld <= 1'b0;
      shadow_reg <= '0;
    end else begin
      if (split_set)      replay_q <= 1'b1;
      else if (pkt_ready) replay_q <= 1'b0;
      shadow_vld <= shadow_nxt_vld;
      shadow_reg <= shadow_nxt_reg;
    end
  end

endmodule

// File: rtl/dih_hazard_chk.sv
module dih_hazard_chk (
  input logic clk,
  input logic rst_n,
  input logic pkt_valid,
  input logic pkt_ready,
  input logic issue0_en,
  input logic issue1_en,
  input logic fetch_stall,
  input logic illegal0,
  input logic illegal1
);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !(issue0_en || issue1_en || pkt_ready || illegal0 || illegal1));

  // R2
  bad_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal0 |-> !issue0_en);

  // R2
  bad_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal1 |-> !issue1_en);

  // R4
  replay_skips_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0_en && !pkt_ready) |=> !issue0_en);

  // R5
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !issue0_en && !issue1_en)
      |=> (!pkt_valid || pkt_ready || issue0_en || issue1_en));

  // R9
  stall_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !pkt_ready);

endmodule

bind dual_issue_hazard dih_hazard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid   (pkt_valid),
  .pkt_ready   (pkt_ready),
  .issue0_en   (issue0_en),
  .issue1_en   (issue1_en),
  .fetch_stall (fetch_stall),
  .illegal0    (illegal0),
  .illegal1    (illegal1)
);

// File: tb/sim_dual_issue_hazard.sv
module sim_dual_issue_hazard;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_word = '0;
  logic        pkt_ready, issue0_en, issue1_en, fetch_stall, illegal0, illegal1;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_hazard u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_word(pkt_word), .issue0_en(issue0_en), .issue1_en(issue1_en),
    .fetch_stall(fetch_stall), .illegal0(illegal0), .illegal1(illegal1)
  );

  // instruction builders (R1 field layout)
  function automatic [31:0] i_add(input [4:0] rd, input [4:0] rs, input [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic [31:0] i_addi(input [4:0] rt, input [4:0] rs);
    return {6'h08, rs, rt, 16'h0004};
  endfunction
  function automatic [31:0] i_beq(input [4:0] rs, input [4:0] rt);
    return {6'h04, rs, rt, 16'h0003};
  endfunction
  function automatic [31:0] i_lw(input [4:0] rt, input [4:0] rs);
    return {6'h23, rs, rt, 16'h0008};
  endfunction
  function automatic [31:0] i_sw(input [4:0] rt, input [4:0] rs);
    return {6'h2B, rs, rt, 16'h000C};
  endfunction

  // bench decode: register 0 stands for "no register"
  typedef struct packed { bit ok; bit nop; bit ld; bit [4:0] dst; bit [4:0] sa; bit [4:0] sb; } bd_t;

  function automatic bd_t bdec(input [31:0] w, input bit mem);
    bd_t d = '0;
    bit [5:0] op = w[31:26];
    if (w == 32'd0) begin d.ok = 1; d.nop = 1; end
    else if (!mem) begin
      if (op == 6'h00) begin d.ok = 1; d.dst = w[15:11]; d.sa = w[25:21]; d.sb = w[20:16]; end
      else if (op == 6'h04 || op == 6'h05) begin d.ok = 1; d.sa = w[25:21]; d.sb = w[20:16]; end
      else if (op >= 6'h08 && op <= 6'h0F) begin d.ok = 1; d.dst = w[20:16]; d.sa = w[25:21]; end
    end else begin
      if (op == 6'h23) begin d.ok = 1; d.ld = 1; d.dst = w[20:16]; d.sa = w[25:21]; end
      else if (op == 6'h2B) begin d.ok = 1; d.sa = w[25:21]; d.sb = w[20:16]; end
    end
    return d;
  endfunction

  bit       m_split = 0;
  bit       m_ldv = 0;
  bit [4:0] m_ld = 0;

  function automatic bit reads(input bd_t d, input bit [4:0] r);
    return (r != 0) && (d.sa == r || d.sb == r);
  endfunction

  // expected vector {i0, i1, ready, stall, ill0, ill1}
  function automatic [5:0] model(input bit v, input [63:0] p,
                                 output bit lu, output bit raw);
    bd_t a = bdec(p[31:0], 1'b0);
    bd_t b = bdec(p[63:32], 1'b1);
    bit rdy;
    lu  = v && m_ldv && ((!m_split && reads(a, m_ld)) || reads(b, m_ld));
    raw = !m_split && reads(b, a.dst);
    rdy = v && !lu && !raw;
    return {v && !lu && !m_split && a.ok && !a.nop,
            v && !lu && !raw && b.ok && !b.nop,
            rdy, v && !rdy, v && !a.ok, v && !b.ok};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_split <= 0; m_ldv <= 0; m_ld <= 0;
    end else begin
      bit lu, raw;
      logic [5:0] e;
      bd_t b;
      e = model(pkt_valid, pkt_word, lu, raw);
      b = bdec(pkt_word[63:32], 1'b1);
      if (pkt_valid && !lu && raw) m_split <= 1;
      else if (e[3]) m_split <= 0;
      m_ldv <= e[4] && b.ld;
      m_ld  <= b.dst;
    end
  end

  task automatic cyc(input bit v, input [63:0] p);
    @(negedge clk);
    pkt_valid = v;
    pkt_word  = p;
    #2;
  endtask

  task automatic expv(input string tag, input [5:0] exp);
    logic [5:0] got = {issue0_en, issue1_en, pkt_ready, fetch_stall, illegal0, illegal1};
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%b exp=%b (i0 i1 rdy stall ill0 ill1)", tag, got, exp);
    end
  endtask

  function automatic [31:0] rnd_alu();
    int k = $urandom % 8;
    bit [4:0] x = 5'($urandom % 4), y = 5'($urandom % 4), z = 5'($urandom % 4);
    case (k)
      0: return 32'd0;
      1, 2: return i_add(x, y, z);
      3, 4: return i_addi(x, y);
      5: return i_beq(x, y);
      6: return i_lw(x, y);
      default: return {6'h3F, 26'h155};
    endcase
  endfunction

  function automatic [31:0] rnd_mem();
    int k = $urandom % 8;
    bit [4:0] x = 5'($urandom % 4), y = 5'($urandom % 4), z = 5'($urandom % 4);
    case (k)
      0: return 32'd0;
      1, 2, 3: return i_lw(x, y);
      4, 5: return i_sw(x, y);
      default: return i_add(x, y, z);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0DD5));
    // R8: outputs quiet in reset
    cyc(0, '0); cyc(0, '0);
    expv("R8 reset idle", 6'b000000);
    @(negedge clk); rst_n = 1'b1;

    // R8: no pending load right after reset
    cyc(1, {32'd0, i_add(5'd3, 5'd0, 5'd2)});
    expv("R8 clean start", 6'b101000);
    // R3: nop in slot 1 not issued
    cyc(1, {32'd0, i_add(5'd3, 5'd1, 5'd2)});
    expv("R3 nop slot1", 6'b101000);
    // R1: slot layout, both issue
    cyc(1, {i_lw(5'd5, 5'd6), i_addi(5'd7, 5'd1)});
    expv("R1 both slots", 6'b111000);
    // R5: slot0 reads r5 from last load
    cyc(1, {32'd0, i_add(5'd8, 5'd5, 5'd1)});
    expv("R5 load-use stall", 6'b000100);
    cyc(1, {32'd0, i_add(5'd8, 5'd5, 5'd1)});
    expv("R5 resume", 6'b101000);
    // R5: slot1 base reads a load result
    cyc(1, {i_lw(5'd9, 5'd1), 32'd0});
    expv("R3 nop slot0", 6'b011000);
    cyc(1, {i_sw(5'd2, 5'd9), 32'd0});
    expv("R5 slot1 stall", 6'b000100);
    cyc(1, {i_sw(5'd2, 5'd9), 32'd0});
    expv("R5 slot1 resume", 6'b011000);
    // R4: split via store data
    cyc(1, {i_sw(5'd3, 5'd1), i_addi(5'd3, 5'd2)});
    expv("R4 split data", 6'b100100);
    cyc(1, {i_sw(5'd3, 5'd1), i_addi(5'd3, 5'd2)});
    expv("R9 replay take", 6'b011000);
    // R4: split via load base
    cyc(1, {i_lw(5'd4, 5'd3), i_add(5'd3, 5'd1, 5'd2)});
    expv("R4 split base", 6'b100100);
    cyc(1, {i_lw(5'd4, 5'd3), i_add(5'd3, 5'd1, 5'd2)});
    expv("R4 replay", 6'b011000);
    // R10: anti-dependence in one packet
    cyc(1, {i_lw(5'd6, 5'd2), i_add(5'd5, 5'd6, 5'd1)});
    expv("R10 anti dep", 6'b111000);
    // R6: register 0 as destination and base
    cyc(1, {i_lw(5'd7, 5'd0), i_add(5'd0, 5'd1, 5'd2)});
    expv("R6 r0 dest", 6'b111000);
    cyc(1, {i_lw(5'd0, 5'd1), 32'd0});
    expv("R6 r0 load", 6'b011000);
    cyc(1, {32'd0, i_add(5'd1, 5'd0, 5'd0)});
    expv("R6 r0 use", 6'b101000);
    // R2: illegal words in both slots
    cyc(1, {i_add(5'd1, 5'd2, 5'd3), i_lw(5'd4, 5'd1)});
    expv("R2 both illegal", 6'b001011);
    cyc(1, {i_add(5'd4, 5'd3, 5'd3), i_addi(5'd3, 5'd2)});
    expv("R2 illegal no hazard", 6'b101001);
    // R3: all-nop packet consumed
    cyc(1, 64'd0);
    expv("R3 nop packet", 6'b001000);
    // R7: idle cycle expires the load shadow
    cyc(1, {i_lw(5'd2, 5'd1), 32'd0});
    expv("R7 load", 6'b011000);
    cyc(0, {32'd0, i_add(5'd3, 5'd2, 5'd2)});
    expv("R7 idle quiet", 6'b000000);
    cyc(1, {32'd0, i_add(5'd3, 5'd2, 5'd2)});
    expv("R7 shadow expired", 6'b101000);

    // constrained random traffic against the bench model
    begin
      bit hold = 0;
      bit v = 0;
      logic [63:0] p = '0;
      for (int n = 0; n < N_RAND; n++) begin
        bit lu, raw;
        logic [5:0] e;
        string tag;
        if (!hold) begin
          v = ($urandom % 8) != 0;
          p = {rnd_mem(), rnd_alu()};
        end
        cyc(v, p);
        e = model(v, p, lu, raw);
        if (e[1] || e[0]) tag = "R2 rand";
        else if (lu) tag = "R5 rand";
        else if (raw || m_split) tag = "R4 rand";
        else if (!v) tag = "R7 rand";
        else tag = "R9 rand";
        expv(tag, e);
        hold = v && !e[3];
      end
    end

    cyc(0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule